// File: doc/BRIEF.md
# Word-packed UART receiver with idle-stale detection

This block is the receive half of a UART. It oversamples the serial line at sixteen times the bit rate, decodes frames of a programmable shape, and packs the received characters four at a time into 32-bit words in a receive FIFO. Software pulls data out one word per read, so each read returns up to four characters.

A transfer is armed by a command. Once it is armed and at least one character has arrived, an idle timer measures the quiet time on the line in whole character times. When the programmed number of character times passes with no new stop bit, the block raises a stale event. At that point it pushes any partially filled word into the FIFO and freezes a snapshot of the number of characters received since the transfer began. From this count, software knows how many bytes of the last word are valid. Software then drains the FIFO and re-arms the transfer with a reset-receive command followed by enable and arm commands.

Register access uses a 3-bit word address with one-cycle write strobes. Read data is registered and appears one cycle after the read strobe. A FIFO read pops one word.

Top module: `wpk_uart_rx`

## Requirements
- R1: Data bits arrive LSB first. The character length is set by mode[5:4] (codes 0,1,2,3 give 5,6,7,8 bits), and unused upper bits of a stored character are zero. A frame whose first stop bit samples low is discarded and is not counted.
- R2: The mode register (address 1) resets to 0x34. Parity mode[1:0] is 0 for none, 1 for odd, 2 for even and 3 for space. Any nonzero code adds one parity bit, whose value is not checked. Stop code mode[3:2] of 0,1,2,3 gives 9,16,25,32 oversample ticks, and this sets the length of one character time.
- R3: Four characters form one word, with the first character in bits 7:0. A word enters the FIFO as soon as its fourth character is received.
- R4: The stale timeout is held in the timeout register (address 2, reset 0x0F, value 0 acts as 1). It counts character times, where one character time is 16×(1+data bits+parity bit) ticks plus the stop ticks. The count restarts at each accepted character. When the timeout expires while the transfer is armed and characters are pending, the block raises a stale event once. Any partial word is pushed with zero upper bytes. The event never fires before the timeout.
- R5: The interrupt status register (address 5) shows the stale flag in bit 3, gated by mask bit 3 at address 3. stale_irq_o is that same gated bit. Channel command 8 clears the flag.
- R6: The snapshot register (address 6) reads 0 until the first stale event of a transfer. It then returns the exact count of characters accepted in that transfer and stays unchanged while the flag is set, even if more characters arrive.
- R7: If a word is pushed while the FIFO is full and no pop happens in the same cycle, the word is dropped. This sets status bit 4 and overrun_o, which stay set until channel command 3.
- R8: A control write (address 0) carries a 5-bit channel command formed from {wdata[11], wdata[7:4]}, and wdata[10:8] holds a general command. Channel command 1 resets the receive path: from the next cycle the FIFO, the packing word, the character count, the snapshot, the stale flag and the arm bit are all cleared, and the receiver is disabled unless wdata[0] is also set.
- R9: Writing 1 to control bit 0 enables the receiver. General command 5 arms the stale event. While the receiver is disabled, line activity stores nothing.
- R10: Reading address 7 pops one FIFO word. A read of an empty FIFO returns 0. Status bit 0 (address 4) is 1 while the FIFO holds data.
- R11: After reset, the status, interrupt status and snapshot registers read 0, the timeout reads 0x0F, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| overrun_o | output | 1 | Sticky receive overrun |
| stale_irq_o | output | 1 | Masked stale event |

## Verification
The bench sends bursts whose length is not a multiple of four in every frame shape. A packer that misplaced the first byte, or that failed to zero the pad bytes of the partial word, would return wrong final words. It also checks the snapshot against the burst length. It checks that no stale event appears shortly after the last stop bit, which catches a timer that counts bits instead of character times. It sends a frame with a bad stop bit to show that the bad character is neither stored nor counted. It fills the FIFO with one word too many: a design that overwrote the FIFO contents, or that let the overrun bit clear itself, would fail the readback. It issues a reset in the middle of a burst, which exposes any leftover packing state mixed into the next word.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  typedef enum logic [2:0] {FR_IDLE, FR_START, FR_DATA, FR_PAR, FR_STOP} fr_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] stop;
    logic [1:0] par;
  } fmt_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_TMO  = 3'd2;
  localparam logic [2:0] A_MASK = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_ISR  = 3'd5;
  localparam logic [2:0] A_SNAP = 3'd6;
  localparam logic [2:0] A_FIFO = 3'd7;

  localparam logic [4:0] CMD_RST_RX    = 5'd1;
  localparam logic [4:0] CMD_RST_ERR   = 5'd3;
  localparam logic [4:0] CMD_CLR_STALE = 5'd8;
  localparam logic [2:0] GCMD_ARM      = 3'd5;

  localparam int STALE_BIT = 3;
  localparam int OVR_BIT   = 4;

  // ticks of 16x oversampling in one character time
  function automatic logic [8:0] char_ticks(fmt_t f);
    logic [8:0] t;
    t = 9'd16 * (9'd6 + 9'(f.len) + 9'(f.par != 2'd0));
    case (f.stop)
      2'd0:    t = t + 9'd9;
      2'd1:    t = t + 9'd16;
      2'd2:    t = t + 9'd25;
      default: t = t + 9'd32;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/wpk_frame_rx.sv
module wpk_frame_rx
  import wpk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rx_i,
  input  fmt_t       fmt_i,
  output logic       chr_vld_o,
  output logic [7:0] chr_o
);
  logic [1:0] sync_q;
  logic       rx_s;
  fr_state_e  st_q;
  logic [3:0] tk_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q;
  logic [2:0] last_bit;

  assign rx_s     = sync_q[1];
  assign last_bit = 3'(fmt_i.len) + 3'd4;
  assign chr_o    = sh_q >> (2'd3 - fmt_i.len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= FR_IDLE;
      tk_q      <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      chr_vld_o <= 1'b0;
    end else begin
      chr_vld_o <= 1'b0;
      if (clr_i || !en_i) begin
        st_q <= FR_IDLE;
      end else if (tick_i) begin
        case (st_q)
          FR_IDLE: if (!rx_s) begin
            st_q <= FR_START;
            tk_q <= '0;
          end
          FR_START: if (tk_q == 4'd7) begin
            tk_q  <= '0;
            bit_q <= '0;
            st_q  <= rx_s ? FR_IDLE : FR_DATA;
          end else tk_q <= tk_q + 4'd1;
          FR_DATA: begin
            tk_q <= tk_q + 4'd1;
            if (tk_q == 4'd15) begin
              sh_q <= {rx_s, sh_q[7:1]};
              if (bit_q == last_bit) st_q <= (fmt_i.par != 2'd0) ? FR_PAR : FR_STOP;
              else                   bit_q <= bit_q + 3'd1;
            end
          end
          FR_PAR: begin
            tk_q <= tk_q + 4'd1;
            if (tk_q == 4'd15) st_q <= FR_STOP;
          end
          FR_STOP: begin
            tk_q <= tk_q + 4'd1;
            if (tk_q == 4'd15) begin
              st_q      <= FR_IDLE;
              chr_vld_o <= rx_s;
            end
          end
          default: st_q <= FR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/wpk_stale_tmr.sv
module wpk_stale_tmr #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [8:0]       span_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             fire_o
);
  logic [8:0]       sub_q;
  logic [TMO_W-1:0] chr_q;
  logic [TMO_W-1:0] tmo_eff;

  assign tmo_eff = (tmo_i == '0) ? TMO_W'(1) : tmo_i;
  assign fire_o  = run_i && !restart_i && (chr_q >= tmo_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      chr_q <= '0;
    end else if (!run_i || restart_i) begin
      sub_q <= '0;
      chr_q <= '0;
    end else if (tick_i && !fire_o) begin
      if (sub_q >= span_i - 9'd1) begin
        sub_q <= '0;
        chr_q <= chr_q + TMO_W'(1);
      end else begin
        sub_q <= sub_q + 9'd1;
      end
    end
  end
endmodule

// File: rtl/wpk_fifo.sv
module wpk_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_o == CW'(DEPTH));
  assign empty_o = (cnt_o == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign head_o  = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_o <= cnt_o + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wp_q] <= data_i;
  end
endmodule

// File: rtl/wpk_uart_rx.sv
module wpk_uart_rx
  import wpk_pkg::*;
#(
  parameter int              CLK_PER_OVS = 4,
  parameter int              FIFO_DEPTH  = 8,
  parameter int              CNT_W       = 16,
  parameter int              TMO_W       = 8,
  parameter logic [TMO_W-1:0] TMO_RST    = TMO_W'(15),
  localparam int DIV_W = (CLK_PER_OVS > 1) ? $clog2(CLK_PER_OVS) : 1,
  localparam int CW    = ((FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        overrun_o,
  output logic        stale_irq_o
);
  logic [DIV_W-1:0] div_q;
  logic             tick;
  fmt_t             mode_q;
  logic [TMO_W-1:0] tmo_q;
  logic             imr_q, rx_en_q, arm_q, stale_q, pend_q, ovr_q;
  logic [CNT_W-1:0] cnt_q, snap_q;
  logic [31:0]      pack_q, push_word, fifo_head, rd_mux;
  logic [1:0]       pack_n_q;
  logic             chr_vld, fire, push, pop, fifo_full, fifo_empty;
  logic [7:0]       chr;
  logic [CW-1:0]    fifo_cnt;
  logic             ctrl_wr, rst_rx, rst_err, clr_stale, arm_cmd;
  logic [4:0]       cmd;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[31:12];

  assign tick = (div_q == DIV_W'(CLK_PER_OVS - 1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + DIV_W'(1);
  end

  assign ctrl_wr   = reg_wr_i && (reg_addr_i == A_CTRL);
  assign cmd       = {reg_wdata_i[11], reg_wdata_i[7:4]};
  assign rst_rx    = ctrl_wr && (cmd == CMD_RST_RX);
  assign rst_err   = ctrl_wr && (cmd == CMD_RST_ERR);
  assign clr_stale = ctrl_wr && (cmd == CMD_CLR_STALE);
  assign arm_cmd   = ctrl_wr && (reg_wdata_i[10:8] == GCMD_ARM);

  wpk_frame_rx u_frame (
    .clk_i, .rst_ni,
    .clr_i     (rst_rx),
    .en_i      (rx_en_q),
    .tick_i    (tick),
    .rx_i,
    .fmt_i     (mode_q),
    .chr_vld_o (chr_vld),
    .chr_o     (chr)
  );

  wpk_stale_tmr #(.TMO_W(TMO_W)) u_tmr (
    .clk_i, .rst_ni,
    .run_i     (arm_q && pend_q && !rst_rx),
    .restart_i (chr_vld),
    .tick_i    (tick),
    .span_i    (char_ticks(mode_q)),
    .tmo_i     (tmo_q),
    .fire_o    (fire)
  );

  assign push      = !rst_rx && ((chr_vld && pack_n_q == 2'd3) || (fire && pack_n_q != 2'd0));
  assign push_word = chr_vld ? {chr, pack_q[23:0]} : pack_q;
  assign pop       = reg_rd_i && (reg_addr_i == A_FIFO);

  wpk_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .clr_i   (rst_rx),
    .push_i  (push),
    .data_i  (push_word),
    .pop_i   (pop),
    .head_o  (fifo_head),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .cnt_o   (fifo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= fmt_t'(6'h34);
      tmo_q  <= TMO_RST;
      imr_q  <= 1'b0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == A_MODE) mode_q <= fmt_t'(reg_wdata_i[5:0]);
      if (reg_addr_i == A_TMO)  tmo_q  <= reg_wdata_i[TMO_W-1:0];
      if (reg_addr_i == A_MASK) imr_q  <= reg_wdata_i[STALE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q  <= 1'b0;
      arm_q    <= 1'b0;
      stale_q  <= 1'b0;
      pend_q   <= 1'b0;
      cnt_q    <= '0;
      snap_q   <= '0;
      pack_q   <= '0;
      pack_n_q <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (rst_err)                                 ovr_q <= 1'b0;
      else if (push && fifo_full && !pop)          ovr_q <= 1'b1;

      if (rst_rx) begin
        rx_en_q  <= reg_wdata_i[0];
        arm_q    <= 1'b0;
        stale_q  <= 1'b0;
        pend_q   <= 1'b0;
        cnt_q    <= '0;
        snap_q   <= '0;
        pack_q   <= '0;
        pack_n_q <= '0;
      end else begin
        if (ctrl_wr && reg_wdata_i[0]) rx_en_q <= 1'b1;
        if (fire)         arm_q <= 1'b0;
        else if (arm_cmd) arm_q <= 1'b1;
        if (clr_stale)    stale_q <= 1'b0;
        else if (fire)    stale_q <= 1'b1;
        if (chr_vld) begin
          pend_q <= 1'b1;
          cnt_q  <= cnt_q + CNT_W'(1);
          if (pack_n_q == 2'd3) begin
            pack_q   <= '0;
            pack_n_q <= '0;
          end else begin
            pack_q[8*pack_n_q +: 8] <= chr;
            pack_n_q <= pack_n_q + 2'd1;
          end
        end else if (fire) begin
          pend_q   <= 1'b0;
          snap_q   <= cnt_q;
          pack_q   <= '0;
          pack_n_q <= '0;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      A_MODE: rd_mux[5:0] = mode_q;
      A_TMO:  rd_mux[TMO_W-1:0] = tmo_q;
      A_MASK: rd_mux[STALE_BIT] = imr_q;
      A_STAT: begin
        rd_mux[0]       = !fifo_empty;
        rd_mux[OVR_BIT] = ovr_q;
      end
      A_ISR:  rd_mux[STALE_BIT] = stale_q & imr_q;
      A_SNAP: rd_mux[CNT_W-1:0] = snap_q;
      A_FIFO: rd_mux = fifo_empty ? '0 : fifo_head;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_rd_i) reg_rdata_o <= rd_mux;
  end

  assign overrun_o   = ovr_q;
  assign stale_irq_o = stale_q & imr_q;
endmodule

// File: rtl/wpk_uart_rx_chk.sv
module wpk_uart_rx_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16,
  parameter int CW         = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [2:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             overrun_o,
  input logic             stale_irq_o,
  input logic             stale_q,
  input logic [CW-1:0]    fifo_cnt,
  input logic [1:0]       pack_n_q,
  input logic [CNT_W-1:0] snap_q
);
  logic       ctrl_wr;
  logic [4:0] cmd;
  assign ctrl_wr = reg_wr_i && (reg_addr_i == 3'd0);
  assign cmd     = {reg_wdata_i[11], reg_wdata_i[7:4]};

  // R7
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !(ctrl_wr && cmd == 5'd3) |=> overrun_o);

  // R7
  ovr_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> fifo_cnt == CW'(FIFO_DEPTH));

  // R8
  rst_rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && cmd == 5'd1 |=> fifo_cnt == '0 && pack_n_q == 2'd0 && !stale_q && snap_q == '0);

  // R5
  stale_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && cmd == 5'd8 |=> !stale_irq_o);

  // R6
  snap_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_q && !reg_wr_i |=> $stable(snap_q));

  // R10
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(FIFO_DEPTH));
endmodule

bind wpk_uart_rx wpk_uart_rx_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .overrun_o   (overrun_o),
  .stale_irq_o (stale_irq_o),
  .stale_q     (stale_q),
  .fifo_cnt    (fifo_cnt),
  .pack_n_q    (pack_n_q),
  .snap_q      (snap_q)
);

// File: tb/wpk_uart_rx_tb.sv
module wpk_uart_rx_tb;
  localparam int OVS   = 2;
  localparam int BIT_C = 16 * OVS;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_i = 1'b1;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        overrun_o, stale_irq_o;

  int checks = 0, errors = 0;
  logic [7:0] sent_q [64];
  int n_sent = 0;
  int cur_len = 3, cur_par = 0, cur_stop = 1;

  always #5 clk_i = ~clk_i;

  wpk_uart_rx #(.CLK_PER_OVS(OVS), .FIFO_DEPTH(DEPTH)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_rd_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic hold(input logic v, input int clks);
    rx_i = v;
    repeat (clks) @(negedge clk_i);
  endtask

  function automatic logic [7:0] lmask();
    return 8'hFF >> (3 - cur_len);
  endfunction

  task automatic send(input logic [7:0] d, input bit bad_stop);
    logic [7:0] m;
    logic p;
    m = d & lmask();
    hold(1'b0, BIT_C);
    for (int i = 0; i < cur_len + 5; i++) hold(m[i], BIT_C);
    if (cur_par != 0) begin
      p = (cur_par == 1) ? ~^m : (cur_par == 2) ? ^m : 1'b0;
      hold(p, BIT_C);
    end
    hold(!bad_stop, BIT_C);
    if (cur_stop == 3) hold(1'b1, BIT_C);
    rx_i = 1'b1;
    if (!bad_stop) begin
      sent_q[n_sent] = m;
      n_sent++;
    end
  endtask

  function automatic logic [31:0] exp_word(input int k);
    logic [31:0] w;
    w = '0;
    for (int b = 0; b < 4; b++)
      if (4 * k + b < n_sent) w[8*b +: 8] = sent_q[4*k+b];
    return w;
  endfunction

  task automatic rearm();
    wr(3'd0, 32'h10);
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h80);
    wr(3'd0, 32'h500);
    n_sent = 0;
  endtask

  task automatic wait_stale(input string req);
    int k;
    k = 0;
    while (!stale_irq_o && k < 8000) begin
      @(negedge clk_i);
      k++;
    end
    check(stale_irq_o, req, {31'd0, stale_irq_o}, 32'd1);
  endtask

  task automatic drain(input string req);
    logic [31:0] v;
    for (int k = 0; k < (n_sent + 3) / 4; k++) begin
      rd(3'd7, v);
      check(v == exp_word(k), req, v, exp_word(k));
    end
    rd(3'd4, v);
    check(v[0] == 1'b0, "R10", v, 32'd0);
    rd(3'd7, v);
    check(v == '0, "R10", v, 32'd0);
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 / R2 reset state
    rd(3'd4, v); check(v == 0, "R11", v, 0);
    rd(3'd5, v); check(v == 0, "R11", v, 0);
    rd(3'd6, v); check(v == 0, "R11", v, 0);
    rd(3'd2, v); check(v == 32'h0F, "R11", v, 32'h0F);
    rd(3'd1, v); check(v == 32'h34, "R2", v, 32'h34);
    check(!overrun_o && !stale_irq_o, "R11", {30'd0, overrun_o, stale_irq_o}, 0);

    // R3 R4 R6 directed 8N1 burst of five
    wr(3'd3, 32'h8);
    wr(3'd2, 32'h2);
    rearm();
    for (int i = 1; i <= 5; i++) send(8'(i * 8'h11), 1'b0);
    repeat (BIT_C * 4) @(negedge clk_i);
    check(!stale_irq_o, "R4", {31'd0, stale_irq_o}, 0);
    wait_stale("R4");
    rd(3'd5, v); check(v == 32'h8, "R5", v, 32'h8);
    wr(3'd3, 32'h0);
    rd(3'd5, v); check(v == 0, "R5", v, 0);
    check(!stale_irq_o, "R5", {31'd0, stale_irq_o}, 0);
    wr(3'd3, 32'h8);
    rd(3'd6, v); check(v == 5, "R6", v, 5);
    drain("R3");
    send(8'hAB, 1'b0);
    repeat (BIT_C * 10) @(negedge clk_i);
    rd(3'd6, v); check(v == 5, "R6", v, 5);
    wr(3'd0, 32'h80);
    check(!stale_irq_o, "R5", {31'd0, stale_irq_o}, 0);

    // R1 R2 random formats
    for (int it = 0; it < 6; it++) begin
      cur_len = int'($urandom_range(3, 0));
      cur_par = int'($urandom_range(3, 0));
      cur_stop = int'($urandom_range(3, 0));
      wr(3'd1, 32'((cur_len << 4) | (cur_stop << 2) | cur_par));
      rearm();
      n = int'($urandom_range(7, 1));
      for (int i = 0; i < n; i++) send(8'($urandom), 1'b0);
      wait_stale("R4");
      rd(3'd6, v); check(v == 32'(n), "R6", v, 32'(n));
      drain("R1");
    end

    // R1 bad stop bit discarded
    cur_len = 3; cur_par = 0; cur_stop = 1;
    wr(3'd1, 32'h34);
    rearm();
    send(8'hC3, 1'b1);
    hold(1'b1, BIT_C * 3);
    send(8'h7E, 1'b0);
    wait_stale("R4");
    rd(3'd6, v); check(v == 1, "R1", v, 1);
    drain("R1");

    // R9 disabled receiver
    wr(3'd0, 32'h10);
    n_sent = 0;
    send(8'h5A, 1'b0);
    repeat (BIT_C * 30) @(negedge clk_i);
    rd(3'd4, v); check(v[0] == 1'b0, "R9", v, 0);
    check(!stale_irq_o, "R9", {31'd0, stale_irq_o}, 0);

    // R8 reset mid burst
    rearm();
    send(8'h01, 1'b0);
    send(8'h02, 1'b0);
    wr(3'd0, 32'h10);
    rd(3'd6, v); check(v == 0, "R8", v, 0);
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h500);
    n_sent = 0;
    send(8'h99, 1'b0);
    wait_stale("R8");
    rd(3'd6, v); check(v == 1, "R8", v, 1);
    drain("R8");

    // R7 overrun
    rearm();
    for (int i = 0; i < 4 * DEPTH + 4; i++) send(8'(i + 3), 1'b0);
    repeat (BIT_C) @(negedge clk_i);
    check(overrun_o, "R7", {31'd0, overrun_o}, 1);
    rd(3'd4, v); check(v == 32'h11, "R7", v, 32'h11);
    wait_stale("R7");
    n_sent = 4 * DEPTH;
    drain("R7");
    check(overrun_o, "R7", {31'd0, overrun_o}, 1);
    wr(3'd0, 32'h30);
    check(!overrun_o, "R7", {31'd0, overrun_o}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule